// File: doc/BRIEF.md
# Down-Spread Clock Modulation Profile Generator

This block computes, once per reference clock, a signed frequency-offset word in parts per million for each of two spread-spectrum synthesizer channels. A fractional divider downstream adds the word to its nominal ratio. The offset traces a symmetric triangle. It starts at zero, falls linearly to the selected negative peak over the first half of each period, and climbs back to zero over the second half. The synthesized frequency therefore never rises above nominal.

Channel A feeds the 100 MHz outputs and has a single enable that applies a fixed -0.5 % (-5000 ppm) depth. Channel B feeds the 80 MHz output and takes a 2-bit depth code whose mapping is not monotonic: 00 is -10000 ppm, 01 is off, 10 is -5000 ppm and 11 is -7500 ppm. Both select inputs are sampled only at the clock edge where the triangle returns to zero. A strobe marks that point. With a 25 MHz reference the default period of 781 cycles gives a modulation rate of about 32 kHz.

Top module: `ssc_profile_gen`

## Requirements
- R1: While rst_ni is low, both offset words are 0 and the strobe is 0. After release, both channels stay at 0 offset until the first strobe, whatever the select inputs are, because reset restores channel A to disabled and channel B to code 01.
- R2: prd_strb_o is high for exactly one clock and repeats every 781 clocks.
- R3: Neither offset word is ever positive (two's complement, bit 15 set or value zero).
- R4: Let the strobe cycle be phase p = 0, counting up by one per clock. Then each offset equals -floor(P * t / 390), where t = p for p <= 390 and t = 781 - p otherwise, and P is the channel's active peak in ppm.
- R5: Channel B's active peak for codes 00, 01, 10 and 11 is 10000, 0, 5000 and 7500 respectively.
- R6: Channel A's active peak is 5000 when its enable is 1 and 0 when its enable is 0.
- R7: The active peak for a period is the select value present at the clock edge that starts its strobe cycle. A select change in the middle of a period does not alter that period's offsets.
- R8: Both offset words are 0 in every strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Global reset, active low, asserted asynchronously and released synchronously |
| ss100_en_i | input | 1 | Channel A spread enable (1 = -5000 ppm) |
| ss80_sel_i | input | 2 | Channel B depth code |
| ofs100_o | output | 16 | Channel A signed offset, ppm |
| ofs80_o | output | 16 | Channel B signed offset, ppm |
| prd_strb_o | output | 1 | High in the cycle where a new triangle period begins |

## Verification
The bench walks through every channel B code and both channel A settings, in an order that goes straight from one nonzero depth to another and from a nonzero depth to off. It compares every cycle of each period against the triangle formula. An accumulator that leaks remainder would drift and fail to return exactly to zero. A wrong peak or a hold at the wrong phase would break the samples around the apex. Changing the selects in mid-period exposes a design that applies depth at once and steps the frequency. A reset taken while a deep spread is selected exposes a design that restores the wrong default, in particular one that treats code 00 rather than 01 as off.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/ssc_phase_gen.sv
module ssc_phase_gen
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 781
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output step_e step_o,
  output logic  wrap_o,
  output logic  strb_o
);

  localparam int unsigned PH_W = $clog2(PERIOD_CYC);
  localparam int unsigned HALF = (PERIOD_CYC - 1) / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            strb_q, strb_d;

  always_comb begin
    wrap_o = (ph_q == PH_LAST);
    ph_d   = wrap_o ? '0 : ph_q + 1'b1;
    strb_d = wrap_o;
    if (ph_q < PH_MID) begin
      step_o = STEP_UP;
    end else if (ph_q == PH_MID) begin
      step_o = STEP_HOLD;
    end else begin
      step_o = STEP_DOWN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      strb_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      strb_q <= strb_d;
    end
  end

  assign strb_o = strb_q;

endmodule

// File: rtl/ssc_depth_dec.sv
module ssc_depth_dec #(
  parameter int unsigned KIND    = 0,
  parameter int unsigned D_ON    = 5000,
  parameter int unsigned D_C0    = 10000,
  parameter int unsigned D_C2    = 5000,
  parameter int unsigned D_C3    = 7500,
  parameter int unsigned HALF    = 390,
  parameter int unsigned MAG_W   = 15,
  parameter int unsigned REM_W   = 9
) (
  input  logic [1:0]       sel_i,
  output logic [MAG_W-1:0] quo_o,
  output logic [REM_W-1:0] rem_o
);

  // KIND 0: enable style, only index 1 carries spread.
  // KIND 1: code style, index 1 is off, the rest map to depths.
  function automatic int unsigned peak_of(int unsigned idx);
    if (KIND == 0) begin
      return (idx == 1) ? D_ON : 0;
    end
    case (idx)
      0:       return D_C0;
      1:       return 0;
      2:       return D_C2;
      default: return D_C3;
    endcase
  endfunction

  logic [MAG_W-1:0] qtab [4];
  logic [REM_W-1:0] rtab [4];

  for (genvar i = 0; i < 4; i++) begin : g_tab
    assign qtab[i] = MAG_W'(peak_of(i) / HALF);
    assign rtab[i] = REM_W'(peak_of(i) % HALF);
  end

  assign quo_o = qtab[sel_i];
  assign rem_o = rtab[sel_i];

endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
  import ssc_pkg::*;
#(
  parameter int unsigned HALF  = 390,
  parameter int unsigned MAG_W = 15,
  parameter int unsigned REM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  step_e            step_i,
  input  logic [MAG_W-1:0] quo_i,
  input  logic [REM_W-1:0] rem_i,
  output logic [MAG_W-1:0] mag_o
);

  localparam logic [REM_W:0] HALF_W = (REM_W + 1)'(HALF);

  logic [MAG_W-1:0] q_act_q, mag_q, mag_d;
  logic [REM_W-1:0] r_act_q, acc_q, acc_d;
  logic [REM_W:0]   sum_up, sum_dn;
  logic             ld_en, run_en;

  always_comb begin
    ld_en  = wrap_i;
    run_en = (step_i != STEP_HOLD);
    sum_up = {1'b0, acc_q} + {1'b0, r_act_q};
    sum_dn = {1'b0, acc_q} + HALF_W - {1'b0, r_act_q};
    mag_d  = mag_q;
    acc_d  = acc_q;
    if (ld_en) begin
      mag_d = '0;
      acc_d = '0;
    end else if (step_i == STEP_UP) begin
      if (sum_up >= HALF_W) begin
        acc_d = REM_W'(sum_up - HALF_W);
        mag_d = mag_q + q_act_q + 1'b1;
      end else begin
        acc_d = REM_W'(sum_up);
        mag_d = mag_q + q_act_q;
      end
    end else if (step_i == STEP_DOWN) begin
      if (acc_q < r_act_q) begin
        acc_d = REM_W'(sum_dn);
        mag_d = mag_q - q_act_q - 1'b1;
      end else begin
        acc_d = acc_q - r_act_q;
        mag_d = mag_q - q_act_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_act_q <= '0;
      r_act_q <= '0;
    end else if (ld_en) begin
      q_act_q <= quo_i;
      r_act_q <= rem_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      acc_q <= '0;
    end else if (ld_en || run_en) begin
      mag_q <= mag_d;
      acc_q <= acc_d;
    end
  end

  assign mag_o = mag_q;

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 781,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned DEPTH_A    = 5000,
  parameter int unsigned DEPTH_B0   = 10000,
  parameter int unsigned DEPTH_B2   = 5000,
  parameter int unsigned DEPTH_B3   = 7500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss100_en_i,
  input  logic [1:0]       ss80_sel_i,
  output logic [OFS_W-1:0] ofs100_o,
  output logic [OFS_W-1:0] ofs80_o,
  output logic             prd_strb_o
);

  localparam int unsigned HALF      = (PERIOD_CYC - 1) / 2;
  localparam int unsigned MAG_W     = OFS_W - 1;
  localparam int unsigned REM_W     = $clog2(HALF + 1);
  localparam int unsigned DEPTH_MAX = max3(DEPTH_B0, max3(DEPTH_B2, DEPTH_B3, 0), DEPTH_A);
  localparam int unsigned MAX_STEP  = DEPTH_MAX / HALF + 1;

  logic             rst_sync_n;
  step_e            step;
  logic             wrap;
  logic [1:0]       sel   [2];
  logic [MAG_W-1:0] quo   [2];
  logic [REM_W-1:0] rem   [2];
  logic [MAG_W-1:0] mag   [2];
  logic [OFS_W-1:0] ofs   [2];

  ssc_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ssc_phase_gen #(
    .PERIOD_CYC (PERIOD_CYC)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .step_o (step),
    .wrap_o (wrap),
    .strb_o (prd_strb_o)
  );

  assign sel[0] = {1'b0, ss100_en_i};
  assign sel[1] = ss80_sel_i;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    ssc_depth_dec #(
      .KIND  (ch),
      .D_ON  (DEPTH_A),
      .D_C0  (DEPTH_B0),
      .D_C2  (DEPTH_B2),
      .D_C3  (DEPTH_B3),
      .HALF  (HALF),
      .MAG_W (MAG_W),
      .REM_W (REM_W)
    ) u_dec (
      .sel_i (sel[ch]),
      .quo_o (quo[ch]),
      .rem_o (rem[ch])
    );

    ssc_ramp #(
      .HALF  (HALF),
      .MAG_W (MAG_W),
      .REM_W (REM_W)
    ) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .wrap_i (wrap),
      .step_i (step),
      .quo_i  (quo[ch]),
      .rem_i  (rem[ch]),
      .mag_o  (mag[ch])
    );

    assign ofs[ch] = OFS_W'(-$signed({1'b0, mag[ch]}));
  end

  assign ofs100_o = ofs[0];
  assign ofs80_o  = ofs[1];

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int unsigned PERIOD_CYC = 781,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned LIM_A      = 5000,
  parameter int unsigned LIM_B      = 10000,
  parameter int unsigned MAX_STEP   = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OFS_W-1:0] ofs100_i,
  input logic [OFS_W-1:0] ofs80_i,
  input logic             strb_i
);

  localparam int unsigned CNT_W = $clog2(PERIOD_CYC) + 1;

  logic [CNT_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= strb_i ? '0 : gap_q + 1'b1;
      seen_q <= seen_q | strb_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni == 1'b0) begin
      AST_RESET_QUIET: assert (ofs100_i == '0 && ofs80_i == '0 && !strb_i); // R1
    end
  end

  AST_STROBE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && strb_i) |-> (gap_q == CNT_W'(PERIOD_CYC - 1))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i |=> !strb_i); // R2

  AST_NEVER_ABOVE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs100_i[OFS_W-1] || ofs100_i == '0)); // R3

  AST_NEVER_ABOVE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs80_i[OFS_W-1] || ofs80_i == '0)); // R3

  AST_DEPTH_LIMIT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'($signed(ofs100_i)) >= -int'(LIM_A)); // R6

  AST_DEPTH_LIMIT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'($signed(ofs80_i)) >= -int'(LIM_B)); // R5

  AST_SMOOTH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'($signed(ofs80_i)) - int'($signed($past(ofs80_i)))) <= int'(MAX_STEP)) &&
    ((int'($signed(ofs80_i)) - int'($signed($past(ofs80_i)))) >= -int'(MAX_STEP)) &&
    ((int'($signed(ofs100_i)) - int'($signed($past(ofs100_i)))) <= int'(MAX_STEP)) &&
    ((int'($signed(ofs100_i)) - int'($signed($past(ofs100_i)))) >= -int'(MAX_STEP))); // R4

  AST_ZERO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i |-> (ofs100_i == '0 && ofs80_i == '0)); // R8

endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .OFS_W      (OFS_W),
  .LIM_A      (DEPTH_A),
  .LIM_B      (DEPTH_MAX),
  .MAX_STEP   (MAX_STEP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ofs100_i (ofs100_o),
  .ofs80_i  (ofs80_o),
  .strb_i   (prd_strb_o)
);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;

  localparam int PERIOD = 781;
  localparam int HALF   = 390;
  localparam int NITEMS = 7;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        ss100_en;
  logic [1:0]  ss80_sel;
  logic [15:0] ofs100, ofs80;
  logic        strb;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_go = 0;
  bit mon_done = 0;

  typedef struct { int pa; int pb; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  ssc_profile_gen u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ss100_en_i (ss100_en),
    .ss80_sel_i (ss80_sel),
    .ofs100_o   (ofs100),
    .ofs80_o    (ofs80),
    .prd_strb_o (strb)
  );

  function automatic int peak_b(logic [1:0] c);
    case (c)
      2'b00:   return 10000;
      2'b01:   return 0;
      2'b10:   return 5000;
      default: return 7500;
    endcase
  endfunction

  function automatic int expect_ofs(int pk, int p);
    int t;
    t = (p <= HALF) ? p : PERIOD - p;
    return -((pk * t) / HALF);
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive_item(bit en, logic [1:0] code);
    exp_t e;
    ss100_en = en;
    ss80_sel = code;
    e.pa = en ? 5000 : 0;
    e.pb = peak_b(code);
    exp_q.push_back(e);
  endtask

  task automatic wait_strobe;
    do @(negedge clk); while (!strb);
  endtask

  // Monitor: scoreboard side, pops one expectation per period.
  initial begin
    exp_t e;
    int gap;
    int p;
    wait (mon_go);
    // R1: defaults hold until the first boundary
    do begin
      @(negedge clk);
      if (!strb) begin
        check("R1 ch100 post-reset", int'($signed(ofs100)), 0);
        check("R1 ch80 post-reset", int'($signed(ofs80)), 0);
      end
    end while (!strb);
    gap = 0;
    for (int per = 0; per < NITEMS; per++) begin
      if (exp_q.size() == 0) begin
        check("R7 scoreboard empty", 0, 1);
        e.pa = 0;
        e.pb = 0;
      end else begin
        e = exp_q.pop_front();
      end
      if (per > 0) check("R2 strobe spacing", gap, PERIOD);
      p = 0;
      gap = 0;
      do begin
        if (p == 0) begin
          check("R8 ch100 zero at strobe", int'($signed(ofs100)), 0);
          check("R8 ch80 zero at strobe", int'($signed(ofs80)), 0);
        end else begin
          check("R2 strobe low mid-period", int'(strb), 0);
        end
        check("R4 R6 R7 ch100", int'($signed(ofs100)), expect_ofs(e.pa, p));
        check("R4 R5 R7 ch80", int'($signed(ofs80)), expect_ofs(e.pb, p));
        check("R3 ch100 not above nominal", int'($signed(ofs100)) > 0, 0);
        check("R3 ch80 not above nominal", int'($signed(ofs80)) > 0, 0);
        @(negedge clk);
        p++;
        gap++;
      end while (!strb && p < PERIOD + 20);
    end
    check("R2 final strobe spacing", gap, PERIOD);
    mon_done = 1;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("[TB] FAIL watchdog actual=timeout expected=completion");
    report();
  end

  // Driver
  initial begin
    ss100_en = 1'b0;
    ss80_sel = 2'b01;
    rst_ni   = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ch100 in reset", int'(ofs100), 0);
    check("R1 ch80 in reset", int'(ofs80), 0);
    check("R1 strobe in reset", int'(strb), 0);
    rst_ni = 1'b1;
    mon_go = 1;
    repeat (300) @(negedge clk);
    drive_item(1'b1, 2'b00);
    for (int k = 1; k < NITEMS; k++) begin
      wait_strobe();
      repeat (300) @(negedge clk);
      case (k)
        1: drive_item(1'b0, 2'b10);
        2: drive_item(1'b1, 2'b11);
        3: drive_item(1'b1, 2'b01);
        4: drive_item(1'b0, 2'b00);
        5: drive_item(1'b0, 2'b11);
        default: drive_item(1'b1, 2'b10);
      endcase
    end
    wait (mon_done);

    // Reset in mid-period with deep spread selected.
    ss100_en = 1'b1;
    ss80_sel = 2'b00;
    repeat (150) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 ch100 reset mid-run", int'(ofs100), 0);
    check("R1 ch80 reset mid-run", int'(ofs80), 0);
    check("R1 strobe reset mid-run", int'(strb), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      check("R1 ch100 default off", int'($signed(ofs100)), 0);
      check("R1 ch80 default off", int'($signed(ofs80)), 0);
    end
    wait_strobe();
    repeat (100) @(negedge clk);
    check("R5 R7 ch80 code 00 after reset", int'($signed(ofs80)), expect_ofs(10000, 100));
    check("R6 R7 ch100 enabled after reset", int'($signed(ofs100)), expect_ofs(5000, 100));
    report();
  end

endmodule